// File: doc/BRIEF.md
# Watchdog Timer with Reset Grace Window

This block is a free-running supervisor timer. It counts system clocks up to one of four selectable intervals. At the end of each interval it raises an interrupt flag. That flag gives software an early warning.

If the reset function is armed and software does not restart the timer within a fixed window of further clocks, the block drives a system reset pulse. It also records that the reset came from the watchdog.

Software reaches the block through a small register port. The arming bit, the interrupt flag and the restart bit sit behind a two-key unlock sequence, so stray writes cannot disturb them. The power-on reset pin clears everything, including the reset-cause flag, and leaves the reset function disarmed.

Top module: `wdog_top`

## Requirements
- R1: After the power-on reset (rst_n low), the three readable registers read 0, and irq and sys_rst are low.
- R2: The interval select field (address 0, bits 1:0) picks 2^(12+3k) clocks for code k. With code 0, irq rises on the 4096th clock after reset or restart. With code 1, it rises on the 32768th clock.
- R3: At each interval end, the interrupt flag (address 1, bit 2) is set, and the irq output follows it. An unlocked write of 0 to bit 2 clears the flag.
- R4: When the arming bit (address 1, bit 1) is 1 and no restart occurs, sys_rst rises 512 clocks after the interval end. It then stays high for 8 clocks, which is two 4-clock machine cycles.
- R5: An unlocked write with bit 0 of address 1 set restarts the count from zero and cancels a pending grace window. Bit 0 reads 1 for one cycle after that write and 0 after it.
- R6: A watchdog reset sets the cause flag (address 1, bit 3) and clears the interrupt flag. A write of 0 to bit 3 clears the cause flag with or without unlock.
- R7: A watchdog reset leaves the arming bit at 1. Counting restarts from zero when the pulse ends, so the next interval end comes 4096 clocks later with code 0.
- R8: Writing 0x5A and then 0xC3 to address 2 on consecutive clocks opens a 4-clock window, readable as address 2, bit 0. Only writes inside this window change bits 0 to 2 of address 1. Writes outside it leave those bits unchanged. Any other cycle between the two keys cancels the sequence.
- R9: With the arming bit at 0, the flag is set at every interval end, sys_rst never rises, and counting continues without pause.
- R10: Register writes made while sys_rst is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 select, 1 control, 2 key |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Interrupt flag |
| sys_rst | output | 1 | Watchdog system reset pulse |

## Verification
The hardest state to reach from the ports is the last clock of the grace window. An unkicked timeout must land exactly 512 clocks after the flag, with the arming bit already set. To get there, the stimulus arms the block while kicking it in the same unlocked write, so that no stale grace window is running. It then lets one full interval run out and counts clocks until sys_rst rises. The edges of the unlock window are reached by placing control writes on the fourth and fifth clock after the second key. A reference model tracks the count, the grace window and the pulse cycle by cycle, so every intermediate clock is compared as well.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_CTL  = 2'd1;
  localparam logic [1:0] ADDR_KEY  = 2'd2;
  localparam logic [7:0] KEY_FIRST  = 8'h5A;
  localparam logic [7:0] KEY_SECOND = 8'hC3;
  localparam int CTL_KICK  = 0;
  localparam int CTL_ARM   = 1;
  localparam int CTL_IRQ   = 2;
  localparam int CTL_CAUSE = 3;
  localparam int SEL_W     = 2;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int WIN_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       open_o
);
  localparam int WW = $clog2(WIN_CLKS + 1);

  logic          stage_q, stage_d;
  logic [WW-1:0] win_q, win_d;

  always_comb begin
    stage_d = 1'b0;
    win_d   = '0;
    if (!hold) begin
      stage_d = key_wr && (key_data == KEY_FIRST);
      if (key_wr && stage_q && (key_data == KEY_SECOND))
        win_d = WW'(WIN_CLKS);
      else if (win_q != '0)
        win_d = win_q - 1'b1;
      else
        win_d = win_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      win_q   <= '0;
    end else begin
      stage_q <= stage_d;
      win_q   <= win_d;
    end
  end

  assign open_o = (win_q != '0);

  // R8
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= WW'(WIN_CLKS));

  // R8
  open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(key_wr && (key_data == KEY_SECOND)));
endmodule

// File: rtl/wdog_interval.sv
module wdog_interval
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tmo_o
);
  localparam int NSEL = 1 << SEL_W;
  localparam int CW   = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_v [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_last
    assign last_v[g] = {CW{1'b1}} >> (CW - BASE_LOG2 - STEP_LOG2 * g);
  end

  assign tmo_o = (cnt_q >= last_v[sel]);

  always_comb begin
    if (clr || tmo_o) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_grace.sv
module wdog_grace #(
  parameter int GRACE_CLKS = 512,
  parameter int RST_CLKS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo,
  input  logic kick,
  input  logic arm,
  output logic fire_o,
  output logic pulse_o
);
  localparam int GW = $clog2(GRACE_CLKS);
  localparam int RW = $clog2(RST_CLKS + 1);

  logic          gact_q, gact_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          expire;

  assign pulse_o = (rcnt_q != '0);
  assign expire  = gact_q && (gcnt_q == GW'(GRACE_CLKS - 1));
  assign fire_o  = expire && arm && !kick && !tmo && !pulse_o;

  always_comb begin
    gact_d = gact_q;
    gcnt_d = gcnt_q;
    if (pulse_o || kick) begin
      gact_d = 1'b0;
      gcnt_d = '0;
    end else if (tmo) begin
      gact_d = 1'b1;
      gcnt_d = '0;
    end else if (expire) begin
      gact_d = 1'b0;
      gcnt_d = '0;
    end else if (gact_q) begin
      gcnt_d = gcnt_q + 1'b1;
    end
  end

  always_comb begin
    if (fire_o)       rcnt_d = RW'(RST_CLKS);
    else if (pulse_o) rcnt_d = rcnt_q - 1'b1;
    else              rcnt_d = rcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gact_q <= 1'b0;
      gcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      gact_q <= gact_d;
      gcnt_q <= gcnt_d;
      rcnt_q <= rcnt_d;
    end
  end

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt_q <= RW'(RST_CLKS));

  // R4
  fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> pulse_o);

  // R5
  kick_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !fire_o);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2  = 12,
  parameter int STEP_LOG2  = 3,
  parameter int GRACE_CLKS = 512,
  parameter int MC_CLKS    = 4,
  parameter int RST_MC     = 2,
  parameter int WIN_CLKS   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       sys_rst
);
  localparam int RST_CLKS = MC_CLKS * RST_MC;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic arm_q, arm_d, irq_q, irq_d, cause_q, cause_d, kick_q, kick_d;
  logic wr_act, key_wr, ctl_wr, cfg_wr, prot_wr, kick;
  logic win_open, tmo_raw, tmo_eff, fire, pulse, cnt_clr;

  always_comb begin
    wr_act  = wr_en && !pulse;
    key_wr  = wr_act && (wr_addr == ADDR_KEY);
    ctl_wr  = wr_act && (wr_addr == ADDR_CTL);
    cfg_wr  = wr_act && (wr_addr == ADDR_CFG);
    prot_wr = ctl_wr && win_open;
    kick    = prot_wr && wr_data[CTL_KICK];
    tmo_eff = tmo_raw && !kick && !pulse;
    cnt_clr = kick || pulse || fire;
  end

  wdog_unlock #(.WIN_CLKS(WIN_CLKS)) u_unlock (
    .clk(clk), .rst_n(rst_n), .hold(pulse), .key_wr(key_wr),
    .key_data(wr_data), .open_o(win_open)
  );

  wdog_interval #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) u_interval (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .sel(sel_q), .tmo_o(tmo_raw)
  );

  wdog_grace #(.GRACE_CLKS(GRACE_CLKS), .RST_CLKS(RST_CLKS)) u_grace (
    .clk(clk), .rst_n(rst_n), .tmo(tmo_eff), .kick(kick), .arm(arm_q),
    .fire_o(fire), .pulse_o(pulse)
  );

  always_comb begin
    sel_d  = cfg_wr ? wr_data[SEL_W-1:0] : sel_q;
    arm_d  = prot_wr ? wr_data[CTL_ARM] : arm_q;
    kick_d = kick;
    if (fire)                            irq_d = 1'b0;
    else if (tmo_eff)                    irq_d = 1'b1;
    else if (prot_wr && !wr_data[CTL_IRQ]) irq_d = 1'b0;
    else                                 irq_d = irq_q;
    if (fire)                              cause_d = 1'b1;
    else if (ctl_wr && !wr_data[CTL_CAUSE]) cause_d = 1'b0;
    else                                   cause_d = cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      arm_q   <= 1'b0;
      irq_q   <= 1'b0;
      cause_q <= 1'b0;
      kick_q  <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      arm_q   <= arm_d;
      irq_q   <= irq_d;
      cause_q <= cause_d;
      kick_q  <= kick_d;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_CFG: rd_data = {{(8-SEL_W){1'b0}}, sel_q};
      ADDR_CTL: rd_data = {4'b0, cause_q, irq_q, arm_q, kick_q};
      ADDR_KEY: rd_data = {7'b0, win_open};
      default:  rd_data = 8'h00;
    endcase
  end

  assign irq     = irq_q;
  assign sys_rst = pulse;

  // R3
  tmo_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_eff |=> irq_q);

  // R5
  kick_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q && !(wr_en && (wr_addr == ADDR_CTL) && wr_data[CTL_KICK]) |=> !kick_q);

  // R8
  arm_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(arm_q));

  // R6
  cause_on_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> cause_q && !irq_q);

  // R7
  arm_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> arm_q);

  // R10
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> $stable(sel_q));
endmodule

// File: tb/tb_wdog_top.sv
`timescale 1ns/1ps
module tb_wdog_top;
  logic       clk, rst_n, wr_en, irq, sys_rst;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  int checks = 0, errors = 0, cyc = 0, rises = 0;
  logic prev_rst = 1'b0;

  // reference model state
  int m_cnt, m_gcnt, m_rcnt, m_win;
  logic m_gact, m_stage, m_arm, m_irq, m_cause, m_kick;
  logic [1:0] m_sel;

  wdog_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .sys_rst(sys_rst)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_gcnt = 0; m_rcnt = 0; m_win = 0;
      m_gact = 0; m_stage = 0; m_arm = 0; m_irq = 0; m_cause = 0;
      m_kick = 0; m_sel = 0;
    end else begin
      logic pulse, wa, keyw, ctlw, cfgw, prot, kick, tmo, fire;
      int limit;
      pulse = (m_rcnt != 0);
      wa    = wr_en && !pulse;
      keyw  = wa && wr_addr == 2'd2;
      ctlw  = wa && wr_addr == 2'd1;
      cfgw  = wa && wr_addr == 2'd0;
      prot  = ctlw && (m_win > 0);
      kick  = prot && wr_data[0];
      limit = 1 << (12 + 3 * m_sel);
      tmo   = !pulse && !kick && (m_cnt >= limit - 1);
      fire  = 0;
      if (pulse || kick) begin m_gact = 0; m_gcnt = 0; end
      else if (tmo) begin m_gact = 1; m_gcnt = 0; end
      else if (m_gact) begin
        if (m_gcnt == 511) begin m_gact = 0; m_gcnt = 0; fire = m_arm; end
        else m_gcnt++;
      end
      if (pulse || kick || fire || tmo) m_cnt = 0; else m_cnt++;
      if (fire) m_rcnt = 8; else if (pulse) m_rcnt--;
      if (fire) m_irq = 0; else if (tmo) m_irq = 1;
      else if (prot && !wr_data[2]) m_irq = 0;
      if (fire) m_cause = 1; else if (ctlw && !wr_data[3]) m_cause = 0;
      if (prot) m_arm = wr_data[1];
      if (cfgw) m_sel = wr_data[1:0];
      m_kick = kick;
      if (pulse) begin m_stage = 0; m_win = 0; end
      else begin
        if (keyw && m_stage && wr_data == 8'hC3) m_win = 4;
        else if (m_win > 0) m_win--;
        m_stage = keyw && wr_data == 8'h5A;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [7:0] e;
    case (rd_addr)
      2'd0: e = {6'd0, m_sel};
      2'd1: e = {4'd0, m_cause, m_irq, m_arm, m_kick};
      2'd2: e = {7'd0, m_win > 0};
      default: e = 8'h00;
    endcase
    chk("R3 irq vs model", irq, m_irq);
    chk("R4 sys_rst vs model", sys_rst, m_rcnt != 0);
    chk("R8 rd_data vs model", rd_data, e);
  endtask

  task automatic tick(input logic we, input logic [1:0] a, input logic [7:0] d);
    wr_en = we; wr_addr = a; wr_data = d; rd_addr = 2'd1;
    @(posedge clk);
    @(negedge clk);
    compare();
    if (sys_rst && !prev_rst) rises++;
    prev_rst = sys_rst;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 2'd0, 8'h00);
  endtask

  task automatic unlock();
    tick(1, 2'd2, 8'h5A);
    tick(1, 2'd2, 8'hC3);
  endtask

  task automatic ctl(input logic [7:0] d);
    tick(1, 2'd1, d);
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_irq(input int maxc, output int n);
    n = 0;
    while (!irq && n < maxc) begin idle(1); n++; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R1 watchdog actual %0d expected below %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] v;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    peek(2'd0, v); chk("R1 select reg after reset", v, 0);
    peek(2'd1, v); chk("R1 control reg after reset", v, 0);
    peek(2'd2, v); chk("R1 window after reset", v, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 sys_rst after reset", sys_rst, 0);

    wait_irq(10000, n); chk("R2 default interval", n, 4096);
    ctl(8'h00); chk("R8 locked flag clear ignored", irq, 1);
    unlock(); ctl(8'h00); chk("R3 unlocked flag clear", irq, 0);

    wait_irq(10000, n); chk("R9 free-running interval", n, 4092);
    chk("R9 no reset while disarmed", rises, 0);

    unlock(); peek(2'd2, v); chk("R8 window open", v, 1);
    idle(4); peek(2'd2, v); chk("R8 window closed after 4", v, 0);
    ctl(8'h00); chk("R8 write after window ignored", irq, 1);
    unlock(); idle(3); ctl(8'h00); chk("R8 write on last window clock", irq, 0);
    tick(1, 2'd2, 8'h5A); tick(1, 2'd3, 8'h00); tick(1, 2'd2, 8'hC3);
    peek(2'd2, v); chk("R8 broken key sequence", v, 0);

    unlock(); ctl(8'h03);
    peek(2'd1, v); chk("R5 restart bit reads 1", v, 8'h03);
    idle(1); peek(2'd1, v); chk("R5 restart bit self-clears", v, 8'h02);
    wait_irq(10000, n); chk("R5 count restarted by kick", n, 4095);
    idle(300); unlock(); ctl(8'h03);
    idle(600); chk("R5 kick cancels grace", rises, 0);

    wait_irq(10000, n); chk("R4 interval before grace", n, 3496);
    n = 0;
    while (!sys_rst && n < 2000) begin idle(1); n++; end
    chk("R4 grace length", n, 512);
    n = 0;
    while (sys_rst && n < 100) begin tick(1, 2'd0, 8'h01); n++; end
    chk("R4 reset pulse width", n, 8);
    peek(2'd0, v); chk("R10 write during pulse ignored", v, 0);
    peek(2'd1, v); chk("R6 cause set, flag cleared, R7 arm kept", v, 8'h0A);
    ctl(8'h00); peek(2'd1, v); chk("R6 cause cleared without unlock", v, 8'h02);
    wait_irq(10000, n); chk("R7 count restarts after pulse", n, 4095);
    chk("R7 single reset so far", rises, 1);
    unlock(); ctl(8'h01);
    peek(2'd1, v); chk("R3 disarm and clear", v, 8'h01);

    tick(1, 2'd0, 8'h03); peek(2'd0, v); chk("R2 select readback", v, 3);
    tick(1, 2'd0, 8'h01); peek(2'd0, v); chk("R2 select code 1", v, 1);
    unlock(); ctl(8'h01);
    wait_irq(40000, n); chk("R2 interval code 1", n, 32768);
    chk("R9 no further reset", rises, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule